// File: doc/BRIEF.md
# Voice Block Address Sequencer

This block walks one playback voice through the compressed sample blocks held in sound RAM. A key-on pulse loads the block address from the start register and immediately asks for the first block. The block then advances a fixed-point position counter by the voice pitch on every sample tick. Whenever the whole-sample part of that counter runs past the end of a 28-sample block, the sequencer moves to the next block and asks for it.

The flag bits that arrive with each block steer the walk. One flag records a loop point. One flag marks the end of a sample. A third flag says whether the end jumps back to the loop point or silences the voice.

Block requests leave on a valid/ready channel. `fetch_valid` stays high with a constant `fetch_byte_addr` until the consumer raises `fetch_ready`. The block's flags come back on a second channel: `blk_ready` is high while the sequencer waits for them, and they are taken in the cycle `blk_valid` is also high. No back-pressure is applied while a block is playing. Each fetch address is also compared with a programmable interrupt address.

Top module: `voice_addr_seq`

## Requirements
- R1: After reset there is no fetch request and no block wait. The block address, repeat address, counter, end flag, key-off, interrupt flag and interrupt pulse all read zero.
- R2: On key-on, the next cycle shows `cur_addr` equal to the start address, a zero counter, a clear end flag and `fetch_valid` high. Key-on takes priority over every other event in that cycle, and it cancels a fetch handshake offered in the same cycle.
- R3: While `fetch_valid` is high and `fetch_ready` is low, the request and its address hold. `fetch_byte_addr` is `cur_addr` times 8, truncated to RAM_AW bits.
- R4: `blk_ready` is high only while a requested block is awaited. When a block is accepted with flag bit 2 (loop start) set, the current block address is copied into the repeat register. This copy wins over a software write in the same cycle.
- R5: While a block is playing, each `sample_tick` adds min(pitch, 0x4000) to the counter. `interp_idx` is counter bits 11:4 and `sample_idx` is the bits above bit 11. Ticks that arrive while no block is playing change nothing.
- R6: When an add makes the sample index 28 or more, 28 samples are subtracted and the next block is requested. If flag bit 0 (loop end) was clear in the block just left, the next block address is the current one plus 2, modulo 2^16.
- R7: When the block just left had loop end (bit 0) and repeat (bit 1) both set, the next block address is the repeat register.
- R8: When the block just left had loop end set and repeat (bit 1) clear, the end flag is set, `key_off` pulses for one cycle, and the block address does not change.
- R9: If `irq_en` is high when a fetch handshake completes, and `irq_addr` equals the fetch block address or that address plus 1, then `irq_flag` is set and `irq_pulse` is high for one cycle.
- R10: `irq_flag` stays set until a cycle in which `irq_en` is low; after that cycle it reads zero.
- R11: A `rep_wr` pulse loads `rep_wdata` into the repeat register. The value appears on `rep_addr` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_on | input | 1 | Start-of-note pulse |
| pitch | input | 16 | Counter increment per sample tick |
| start_addr | input | 16 | Start block address, in 8-byte units |
| rep_wr | input | 1 | Software write strobe for the repeat register |
| rep_wdata | input | 16 | Software value for the repeat register |
| rep_addr | output | 16 | Repeat register |
| irq_en | input | 1 | Interrupt enable; when low, clears the interrupt flag |
| irq_addr | input | 16 | Interrupt match address, in 8-byte units |
| sample_tick | input | 1 | One output-sample step |
| fetch_valid | output | 1 | Block fetch request |
| fetch_ready | input | 1 | Fetch request accepted |
| fetch_byte_addr | output | RAM_AW | Byte address of the requested block |
| blk_valid | input | 1 | Flags of the fetched block are present |
| blk_ready | output | 1 | Waiting for block flags |
| blk_flags | input | 3 | Bit 0 loop end, bit 1 repeat, bit 2 loop start |
| cur_addr | output | 16 | Current block address |
| sample_idx | output | SIDX_W | Whole-sample position inside the block |
| interp_idx | output | 8 | Fractional position for the interpolator |
| end_flag | output | 1 | Voice reached a non-repeating end |
| key_off | output | 1 | One-cycle key-off pulse to the envelope |
| irq_flag | output | 1 | Sticky interrupt-address hit |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
The bench builds the block with RAM_AW set to 12. This puts the byte-address truncation within reach: block 0x0300 maps to byte 0x800, and the start address 0xFFFE wraps to 0 on its next advance. The other parameters keep their defaults. With the 0x4000 pitch cap in force, seven ticks finish a block, so loop captures, repeat jumps, end-of-sample mutes and both halves of the interrupt match all occur within a few hundred cycles. Fetch acceptance is stalled by up to two cycles to exercise the request hold.

// File: rtl/voice_seq_pkg.sv
package voice_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2,
    SQ_PLAY = 2'd3
  } seq_state_t;

  // Bit positions of the per-block flag field.
  localparam int FLG_END    = 0;
  localparam int FLG_RPT    = 1;
  localparam int FLG_LSTART = 2;
  localparam int FLG_W      = 3;
endpackage

// File: rtl/vseq_pos_counter.sv
module vseq_pos_counter #(
  parameter int PITCH_W     = 16,
  parameter int FRAC_W      = 12,
  parameter int IDX_W       = 8,
  parameter int BLK_SAMPLES = 28,
  parameter int PITCH_CAP   = 16384,
  localparam int SIDX_W     = $clog2(BLK_SAMPLES + (PITCH_CAP >> FRAC_W) + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               advance,
  input  logic [PITCH_W-1:0] pitch,
  output logic [SIDX_W-1:0]  sample_idx,
  output logic [IDX_W-1:0]   interp_idx,
  output logic               wrap
);
  localparam int CNT_W = SIDX_W + FRAC_W;
  localparam logic [CNT_W:0] CAP_V  = (CNT_W+1)'(PITCH_CAP);
  localparam logic [CNT_W:0] BLK_V  = (CNT_W+1)'(BLK_SAMPLES) << FRAC_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   step, sum;

  always_comb begin
    step = ((CNT_W+1)'(pitch) > CAP_V) ? CAP_V : (CNT_W+1)'(pitch);
    sum  = {1'b0, cnt_q} + step;
    wrap = advance && (sum >= BLK_V);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt_q <= '0;
    else if (wrap)       cnt_q <= CNT_W'(sum - BLK_V);
    else if (advance)    cnt_q <= CNT_W'(sum);
  end

  assign sample_idx = cnt_q[CNT_W-1:FRAC_W];
  assign interp_idx = cnt_q[FRAC_W-1 -: IDX_W];

  // R5: the whole-sample index never rests past the block end
  a_r5_idx_in_block: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(sample_idx) < BLK_SAMPLES));

  // R6: leaving a block moves the sample index backwards
  a_r6_wrap_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !clear) |=> (sample_idx < $past(sample_idx)));
endmodule

// File: rtl/vseq_irq_watch.sv
module vseq_irq_watch #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [ADDR_W-1:0] match_addr,
  input  logic              fetch_fire,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              flag,
  output logic              pulse
);
  logic [ADDR_W-1:0] upper_half;
  logic              hit;

  always_comb begin
    upper_half = fetch_addr + ADDR_W'(1);
    hit = fetch_fire && ((match_addr == fetch_addr) || (match_addr == upper_half));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      pulse <= 1'b0;
    end else begin
      pulse <= enable && hit;
      flag  <= enable && (flag || hit);
    end
  end

  // R10: a disabled cycle leaves the flag clear
  a_r10_clear_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !flag);

  // R9: a request pulse always comes with the sticky flag
  a_r9_pulse_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> flag);
endmodule

// File: rtl/voice_addr_seq.sv
module voice_addr_seq
  import voice_seq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PITCH_W     = 16,
  parameter int FRAC_W      = 12,
  parameter int IDX_W       = 8,
  parameter int BLK_SAMPLES = 28,
  parameter int PITCH_CAP   = 16384,
  parameter int UNIT_SHIFT  = 3,
  parameter int ADDR_STEP   = 2,
  parameter int RAM_AW      = 19,
  localparam int SIDX_W     = $clog2(BLK_SAMPLES + (PITCH_CAP >> FRAC_W) + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               key_on,
  input  logic [PITCH_W-1:0] pitch,
  input  logic [ADDR_W-1:0]  start_addr,
  input  logic               rep_wr,
  input  logic [ADDR_W-1:0]  rep_wdata,
  output logic [ADDR_W-1:0]  rep_addr,
  input  logic               irq_en,
  input  logic [ADDR_W-1:0]  irq_addr,
  input  logic               sample_tick,
  output logic               fetch_valid,
  input  logic               fetch_ready,
  output logic [RAM_AW-1:0]  fetch_byte_addr,
  input  logic               blk_valid,
  output logic               blk_ready,
  input  logic [FLG_W-1:0]   blk_flags,
  output logic [ADDR_W-1:0]  cur_addr,
  output logic [SIDX_W-1:0]  sample_idx,
  output logic [IDX_W-1:0]   interp_idx,
  output logic               end_flag,
  output logic               key_off,
  output logic               irq_flag,
  output logic               irq_pulse
);
  localparam int FULL_W = ADDR_W + UNIT_SHIFT;
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(ADDR_STEP);

  seq_state_t        state_q;
  logic [ADDR_W-1:0] cur_q, rep_q;
  logic [FLG_W-1:0]  flags_q;
  logic              end_q, koff_q;
  logic              fire, advance, wrap;
  logic [FULL_W-1:0] byte_full;

  always_comb begin
    fetch_valid = (state_q == SQ_REQ);
    blk_ready   = (state_q == SQ_WAIT);
    fire        = fetch_valid && fetch_ready && !key_on;
    advance     = sample_tick && (state_q == SQ_PLAY) && !key_on;
    byte_full   = {cur_q, {UNIT_SHIFT{1'b0}}};
  end

  generate
    if (RAM_AW <= FULL_W) begin : g_trunc
      assign fetch_byte_addr = byte_full[RAM_AW-1:0];
    end else begin : g_extend
      assign fetch_byte_addr = {{(RAM_AW-FULL_W){1'b0}}, byte_full};
    end
  endgenerate

  vseq_pos_counter #(
    .PITCH_W(PITCH_W), .FRAC_W(FRAC_W), .IDX_W(IDX_W),
    .BLK_SAMPLES(BLK_SAMPLES), .PITCH_CAP(PITCH_CAP)
  ) u_pos (
    .clk(clk), .rst_n(rst_n), .clear(key_on), .advance(advance),
    .pitch(pitch), .sample_idx(sample_idx), .interp_idx(interp_idx), .wrap(wrap)
  );

  vseq_irq_watch #(.ADDR_W(ADDR_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .enable(irq_en), .match_addr(irq_addr),
    .fetch_fire(fire), .fetch_addr(cur_q), .flag(irq_flag), .pulse(irq_pulse)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cur_q   <= '0;
      rep_q   <= '0;
      flags_q <= '0;
      end_q   <= 1'b0;
      koff_q  <= 1'b0;
    end else begin
      koff_q <= 1'b0;
      if (rep_wr) rep_q <= rep_wdata;
      if (key_on) begin
        cur_q   <= start_addr;
        end_q   <= 1'b0;
        state_q <= SQ_REQ;
      end else begin
        unique case (state_q)
          SQ_REQ:  if (fetch_ready) state_q <= SQ_WAIT;
          SQ_WAIT: if (blk_valid) begin
            flags_q <= blk_flags;
            if (blk_flags[FLG_LSTART]) rep_q <= cur_q;
            state_q <= SQ_PLAY;
          end
          SQ_PLAY: if (wrap) begin
            state_q <= SQ_REQ;
            if (flags_q[FLG_END]) begin
              if (flags_q[FLG_RPT]) cur_q <= rep_q;
              else begin
                end_q  <= 1'b1;
                koff_q <= 1'b1;
              end
            end else begin
              cur_q <= cur_q + STEP_V;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign cur_addr = cur_q;
  assign rep_addr = rep_q;
  assign end_flag = end_q;
  assign key_off  = koff_q;

  // R2: key-on loads the start address and clears the end flag
  a_r2_keyon_load: assert property (@(posedge clk) disable iff (!rst_n)
    key_on |=> (cur_addr == $past(start_addr)) && !end_flag && fetch_valid);

  // R3: a stalled request holds with a stable address
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready && !key_on) |=> fetch_valid && $stable(fetch_byte_addr));

  // R4: a loop-start block copies its address into the repeat register
  a_r4_loop_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_ready && blk_valid && blk_flags[FLG_LSTART] && !key_on)
      |=> (rep_addr == $past(cur_addr)));

  // R7: leaving a repeating end jumps to the repeat register
  a_r7_repeat_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && flags_q[FLG_END] && flags_q[FLG_RPT] && !key_on)
      |=> (cur_addr == $past(rep_q)));

  // R8: a key-off pulse is always accompanied by the end flag
  a_r8_koff_end: assert property (@(posedge clk) disable iff (!rst_n)
    key_off |-> end_flag);
endmodule

// File: tb/test_voice_addr_seq.sv
`timescale 1ns/1ps
module test_voice_addr_seq;
  localparam int RAM_AW = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_on = 1'b0;
  logic [15:0] pitch = '0;
  logic [15:0] start_addr = '0;
  logic        rep_wr = 1'b0;
  logic [15:0] rep_wdata = '0;
  logic [15:0] rep_addr;
  logic        irq_en = 1'b0;
  logic [15:0] irq_addr = '0;
  logic        sample_tick = 1'b0;
  logic        fetch_valid;
  logic        fetch_ready = 1'b0;
  logic [RAM_AW-1:0] fetch_byte_addr;
  logic        blk_valid = 1'b0;
  logic        blk_ready;
  logic [2:0]  blk_flags = '0;
  logic [15:0] cur_addr;
  logic [5:0]  sample_idx;
  logic [7:0]  interp_idx;
  logic        end_flag, key_off, irq_flag, irq_pulse;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  voice_addr_seq #(.RAM_AW(RAM_AW)) i_voice_addr_seq (
    .clk(clk), .rst_n(rst_n), .key_on(key_on), .pitch(pitch),
    .start_addr(start_addr), .rep_wr(rep_wr), .rep_wdata(rep_wdata),
    .rep_addr(rep_addr), .irq_en(irq_en), .irq_addr(irq_addr),
    .sample_tick(sample_tick), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_byte_addr(fetch_byte_addr), .blk_valid(blk_valid), .blk_ready(blk_ready),
    .blk_flags(blk_flags), .cur_addr(cur_addr), .sample_idx(sample_idx),
    .interp_idx(interp_idx), .end_flag(end_flag), .key_off(key_off),
    .irq_flag(irq_flag), .irq_pulse(irq_pulse)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act %0h exp %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Block flag source: addresses chosen per scenario.
  int ls_at = -1, rpt_at = -1, end_at = -1;
  int stall_cfg = 0, stall_left = 0;

  function automatic logic [2:0] flags_for(int a);
    logic [2:0] f = 3'b000;
    if (a == ls_at)  f[2] = 1'b1;
    if (a == rpt_at) f[1:0] = 2'b11;
    if (a == end_at) f[0] = 1'b1;
    return f;
  endfunction

  always @(negedge clk) begin
    fetch_ready = 1'b0;
    blk_valid = 1'b0;
    if (fetch_valid) begin
      if (stall_left > 0) stall_left--;
      else begin
        fetch_ready = 1'b1;
        stall_left = stall_cfg;
      end
    end
    if (blk_ready) begin
      blk_valid = 1'b1;
      blk_flags = flags_for(int'(cur_addr));
    end
  end

  // Behavioural reference: 0 idle, 1 requesting, 2 awaiting, 3 playing.
  int m_st, m_addr, m_rep, m_cnt, m_flags, m_old_rep, m_step;
  bit m_end, m_koff, m_irqf, m_irqp, m_hit;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_addr = 0; m_rep = 0; m_cnt = 0; m_flags = 0;
      m_end = 0; m_koff = 0; m_irqf = 0; m_irqp = 0;
    end else begin
      m_old_rep = m_rep;
      m_koff = 0;
      m_hit = 0;
      if (rep_wr) m_rep = int'(rep_wdata);
      if (key_on) begin
        m_addr = int'(start_addr); m_cnt = 0; m_end = 0; m_st = 1;
      end else begin
        case (m_st)
          1: if (fetch_ready) begin
            if (m_addr == int'(irq_addr) || ((m_addr + 1) & 16'hFFFF) == int'(irq_addr)) m_hit = 1;
            m_st = 2;
          end
          2: if (blk_valid) begin
            m_flags = int'(blk_flags);
            if (blk_flags[2]) m_rep = m_addr;
            m_st = 3;
          end
          3: if (sample_tick) begin
            m_step = (int'(pitch) > 16384) ? 16384 : int'(pitch);
            m_cnt += m_step;
            if ((m_cnt >> 12) >= 28) begin
              m_cnt -= 28 * 4096;
              m_st = 1;
              if (m_flags[0]) begin
                if (m_flags[1]) m_addr = m_old_rep;
                else begin m_end = 1; m_koff = 1; end
              end else m_addr = (m_addr + 2) & 16'hFFFF;
            end
          end
          default: ;
        endcase
      end
      m_irqp = irq_en && m_hit;
      m_irqf = irq_en && (m_irqf || m_hit);
    end
  end

  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk("R2 R3 fetch_valid", int'(fetch_valid), int'(m_st == 1));
      chk("R3 fetch_byte_addr", int'(fetch_byte_addr), (m_addr * 8) & ((1 << RAM_AW) - 1));
      chk("R4 blk_ready", int'(blk_ready), int'(m_st == 2));
      chk("R6 R7 cur_addr", int'(cur_addr), m_addr);
      chk("R4 R11 rep_addr", int'(rep_addr), m_rep);
      chk("R5 R6 sample_idx", int'(sample_idx), m_cnt >> 12);
      chk("R5 interp_idx", int'(interp_idx), (m_cnt >> 4) & 255);
      chk("R8 end_flag", int'(end_flag), int'(m_end));
      chk("R8 key_off", int'(key_off), int'(m_koff));
      chk("R9 R10 irq_flag", int'(irq_flag), int'(m_irqf));
      chk("R9 irq_pulse", int'(irq_pulse), int'(m_irqp));
    end
  end

  task automatic run(int n, int tick_every);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample_tick = (tick_every > 0) && ((i % tick_every) == 0);
    end
  endtask

  task automatic press(logic [15:0] a);
    @(negedge clk);
    start_addr = a;
    key_on = 1'b1;
    @(negedge clk);
    key_on = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 fetch_valid", int'(fetch_valid), 0);
    chk("R1 blk_ready", int'(blk_ready), 0);
    chk("R1 cur_addr", int'(cur_addr), 0);
    chk("R1 rep_addr", int'(rep_addr), 0);
    chk("R1 sample_idx", int'(sample_idx), 0);
    chk("R1 end_flag", int'(end_flag), 0);
    chk("R1 irq_flag", int'(irq_flag), 0);
    cmp_on = 1;

    // R2 R3 R5 R6: plain advance, one sample per tick, stalled fetches
    stall_cfg = 2;
    pitch = 16'h1000;
    press(16'h0100);
    run(200, 1);

    // R4 R7: capped pitch, loop capture and repeat jump
    stall_cfg = 0;
    pitch = 16'hFFFF;
    ls_at = 16'h0200; rpt_at = 16'h0204;
    press(16'h0200);
    run(100, 1);

    // R9 R10: interrupt on either half, then disable
    irq_en = 1'b1; irq_addr = 16'h0203;
    run(60, 1);
    irq_addr = 16'h0204;
    run(60, 1);
    irq_en = 1'b0;
    run(5, 1);
    chk("R10 flag cleared", int'(irq_flag), 0);

    // R11 R8: software repeat write steers into a muting end block
    @(negedge clk);
    rep_wr = 1'b1; rep_wdata = 16'h0300;
    @(negedge clk);
    rep_wr = 1'b0;
    end_at = 16'h0300; ls_at = -1;
    run(120, 1);
    chk("R8 end_flag set", int'(end_flag), 1);
    chk("R8 addr held", int'(cur_addr), 16'h0300);

    // R2 R5: key-on clears end; fractional pitch with sparse ticks
    pitch = 16'h0123;
    press(16'h0300);
    chk("R2 end cleared", int'(end_flag), 0);
    run(400, 3);

    // R3 R6: address wrap near the top of the block space
    end_at = -1; rpt_at = -1;
    pitch = 16'h4000;
    stall_cfg = 1;
    press(16'hFFFE);
    run(80, 1);

    cmp_on = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule